// File: doc/BRIEF.md
# Iterative Fractional Divider

The block divides a non-negative 16-bit numerator by a non-negative 16-bit denominator that is at least as large, and returns the quotient as a Q15 fraction. It uses restoring division and settles one quotient bit per clock. A run of 15 such steps starts from a zero quotient and from a partial remainder equal to the numerator. The partial remainder is kept in a register twice the operand width, so doubling it can never wrap.

A caller drives the operands together with a one-cycle `start_i`. It then watches `busy_o` while the iterations run and takes `quot_o` when `done_o` pulses. Two cases finish one edge after the start and never raise `busy_o`: operands that are equal and valid, and operands outside the supported domain. Operands outside the domain do not produce a quotient. Instead they raise `err_o`. The result outputs hold their value until the next operation completes.

Top module: `frac_div`

## Requirements
- R1: While `rst_ni` is low and after it rises, `busy_o`, `done_o` and `err_o` are 0 and `quot_o` is 0x0000.
- R2: A `start_i` sampled while idle, with a valid and unequal operand pair, sets `busy_o` from the next edge. `done_o` is high for exactly one cycle, after the 15th clock edge following the accepting edge, and `busy_o` drops on that same edge.
- R3: For a valid pair with numerator below denominator, `quot_o` equals floor(num * 32768 / den). Each step doubles the remainder, subtracts the denominator when the doubled remainder is not smaller, and shifts that decision into the quotient LSB.
- R4: Equal, valid, non-zero operands give `quot_o` = 0x7FFF and `err_o` = 0 with `done_o` one edge after the start, and `busy_o` stays low.
- R5: A zero denominator, bit 15 set in either operand, or a numerator above the denominator gives `err_o` = 1 and `quot_o` = 0x0000 with `done_o` one edge after the start, and `busy_o` stays low. This check takes priority over the equal-operand case, so 0/0 and 0x8000/0x8000 are errors.
- R6: A `start_i` sampled while `busy_o` is high is ignored. It changes neither the timing nor the result of the running division, even on the final iteration edge.
- R7: `quot_o` and `err_o` change only on the edge that raises `done_o`, and otherwise hold the last result.
- R8: A `start_i` sampled in the cycle where `done_o` is high is accepted, so `start_i` held high runs divisions back to back.
- R9: Every successful result has bit 15 of `quot_o` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division with the present operands |
| num_i | input | 16 | Numerator |
| den_i | input | 16 | Denominator |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 16 | Q15 quotient of the last completed operation |
| err_o | output | 1 | Last completed operation had unsupported operands |

## Verification
Completion of one division and acceptance of the next request can fall on the same edge. The bench holds `start_i` high across whole runs, so a new operand pair is presented exactly in the `done_o` cycle. The behavioural model must then see the new run start while the old result is being reported. The opposite collision is also provoked: a request driven into the last iteration cycle, which must be dropped. The bench judges both cases by comparing `busy_o`, `done_o`, `quot_o` and `err_o` against the model on every clock.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  typedef enum logic [1:0] {
    OPC_ITER   = 2'd0,
    OPC_UNITY  = 2'd1,
    OPC_REJECT = 2'd2
  } op_class_e;
endpackage

// File: rtl/frac_div_classify.sv
module frac_div_classify
  import frac_div_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] num_i,
  input  logic [DATA_W-1:0] den_i,
  output op_class_e         cls_o
);
  logic reject;

  // rejection outranks equality
  assign reject = (den_i == '0) || num_i[DATA_W-1] || den_i[DATA_W-1] || (num_i > den_i);

  always_comb begin
    if (reject)              cls_o = OPC_REJECT;
    else if (num_i == den_i) cls_o = OPC_UNITY;
    else                     cls_o = OPC_ITER;
  end
endmodule

// File: rtl/frac_div_step.sv
module frac_div_step #(
  parameter int DATA_W = 16,
  parameter int REM_W  = 2 * DATA_W
) (
  input  logic [REM_W-1:0]  rem_i,
  input  logic [DATA_W-1:0] den_i,
  input  logic [DATA_W-1:0] quo_i,
  output logic [REM_W-1:0]  rem_o,
  output logic [DATA_W-1:0] quo_o
);
  logic [REM_W-1:0] rem_dbl;
  logic [REM_W-1:0] den_ext;
  logic             take;

  assign rem_dbl = {rem_i[REM_W-2:0], 1'b0};
  assign den_ext = REM_W'(den_i);
  assign take    = (rem_dbl >= den_ext);
  assign rem_o   = take ? (rem_dbl - den_ext) : rem_dbl;
  assign quo_o   = {quo_i[DATA_W-2:0], take};
endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
  import frac_div_pkg::*;
#(
  parameter int ITERS = 15,
  localparam int CNT_W = $clog2(ITERS + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  op_class_e cls_i,
  output logic      busy_o,
  output logic      load_o,
  output logic      quick_o,
  output logic      last_o,
  output logic      done_o
);
  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept  = start_i && !busy_q;
  assign load_o  = accept && (cls_i == OPC_ITER);
  assign quick_o = accept && (cls_i != OPC_ITER);
  assign last_o  = busy_q && (cnt_q == CNT_W'(ITERS - 1));
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= quick_o || last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CNT_W'(ITERS))); // R2
  AST_BUSY_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !done_q); // R2
  AST_DONE_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q); // R2
endmodule

// File: rtl/frac_div.sv
module frac_div
  import frac_div_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ITERS = DATA_W - 1,
  localparam int REM_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] num_i,
  input  logic [DATA_W-1:0] den_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] quot_o,
  output logic              err_o
);
  localparam logic [DATA_W-1:0] UNITY_Q = {1'b0, {(DATA_W-1){1'b1}}};

  op_class_e         cls;
  logic              load, quick, last;
  logic [REM_W-1:0]  rem_q, rem_nxt;
  logic [DATA_W-1:0] den_q, quo_q, quo_nxt;
  logic [DATA_W-1:0] res_q;
  logic              err_q;

  frac_div_classify #(.DATA_W(DATA_W)) u_cls (
    .num_i (num_i),
    .den_i (den_i),
    .cls_o (cls)
  );

  frac_div_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cls_i   (cls),
    .busy_o  (busy_o),
    .load_o  (load),
    .quick_o (quick),
    .last_o  (last),
    .done_o  (done_o)
  );

  frac_div_step #(.DATA_W(DATA_W), .REM_W(REM_W)) u_step (
    .rem_i (rem_q),
    .den_i (den_q),
    .quo_i (quo_q),
    .rem_o (rem_nxt),
    .quo_o (quo_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
    end else if (load) begin
      rem_q <= REM_W'(num_i);
      den_q <= den_i;
      quo_q <= '0;
    end else if (busy_o) begin
      rem_q <= rem_nxt;
      quo_q <= quo_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      err_q <= 1'b0;
    end else if (last) begin
      res_q <= quo_nxt;
      err_q <= 1'b0;
    end else if (quick) begin
      err_q <= (cls == OPC_REJECT);
      res_q <= (cls == OPC_UNITY) ? UNITY_Q : '0;
    end
  end

  assign quot_o = res_q;
  assign err_o  = err_q;

  AST_REM_BELOW_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rem_q < REM_W'(den_q))); // R3
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (quot_o == '0)); // R5
  AST_RESULT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !quot_o[DATA_W-1]); // R9
  AST_IGNORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(den_q)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(quot_o) |-> done_o); // R7
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_o) |-> done_o); // R7
endmodule

// File: tb/tb_frac_div.sv
module tb_frac_div;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] num_i = '0;
  logic [15:0] den_i = '0;
  logic        busy_o, done_o, err_o;
  logic [15:0] quot_o;

  frac_div dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .num_i(num_i), .den_i(den_i),
    .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o), .err_o(err_o)
  );

  always #4 clk_i = ~clk_i;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  string req_tag = "R1";

  // behavioural model state
  bit    m_busy, m_done, m_err;
  int    m_cnt, m_q, m_pend;
  string m_qtag = "R1";

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0; m_q = 0; m_qtag = "R1";
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 15) begin
          m_busy = 0; m_done = 1; m_q = m_pend; m_err = 0; m_qtag = "R3";
        end
      end else if (start_i) begin
        if (den_i == 0 || num_i[15] || den_i[15] || num_i > den_i) begin
          m_done = 1; m_err = 1; m_q = 0; m_qtag = "R5";
        end else if (num_i == den_i) begin
          m_done = 1; m_err = 0; m_q = 32'h7FFF; m_qtag = "R4";
        end else begin
          m_busy = 1; m_cnt = 0;
          m_pend = int'((longint'(num_i) * 64'd32768) / longint'(den_i));
        end
      end
    end
  end

  always @(negedge clk_i) begin
    cyc++;
    chk(req_tag, "busy_o", int'(busy_o), int'(m_busy));
    chk(req_tag, "done_o", int'(done_o), int'(m_done));
    chk(m_done ? m_qtag : (rst_ni ? "R7" : "R1"), "quot_o", int'(quot_o), m_q);
    chk(m_done ? m_qtag : (rst_ni ? "R7" : "R1"), "err_o", int'(err_o), int'(m_err));
    if (done_o && !err_o) chk("R9", "quot_o[15]", int'(quot_o[15]), 0);
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_idle();
    do @(negedge clk_i); while (m_busy);
    @(negedge clk_i);
  endtask

  task automatic op(logic [15:0] n, logic [15:0] d);
    @(negedge clk_i);
    start_i = 1'b1; num_i = n; den_i = d;
    @(negedge clk_i);
    start_i = 1'b0;
    num_i = $urandom(); den_i = $urandom();
    wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    req_tag = "R2";
    op(16'd1, 16'd2);
    op(16'd1, 16'd3);
    op(16'd0, 16'd5);
    op(16'h7FFE, 16'h7FFF);
    op(16'd1, 16'h7FFF);
    req_tag = "R4";
    op(16'd100, 16'd100);
    op(16'h7FFF, 16'h7FFF);
    req_tag = "R5";
    op(16'd7, 16'd0);
    op(16'd0, 16'd0);
    op(16'h8000, 16'h8000);
    op(16'd3, 16'h9000);
    op(16'd10, 16'd5);

    // request flood during a run, including the final iteration cycle
    req_tag = "R6";
    @(negedge clk_i);
    start_i = 1'b1; num_i = 16'd1; den_i = 16'd3;
    @(negedge clk_i);
    while (m_busy) begin
      start_i = 1'b1; num_i = 16'd2; den_i = 16'd5;
      @(negedge clk_i);
      if (!m_busy) start_i = 1'b0;
    end
    start_i = 1'b0;
    chk("R6", "quot_o after flood", int'(quot_o), 32768 / 3);
    chk("R6", "done_o after flood", int'(done_o), 1);
    wait_idle();

    // start held high: restart in the done cycle
    req_tag = "R8";
    @(negedge clk_i);
    start_i = 1'b1; num_i = 16'd3; den_i = 16'd7;
    repeat (17) @(negedge clk_i);
    chk("R8", "busy_o in restart", int'(busy_o), 1);
    repeat (20) @(negedge clk_i);
    start_i = 1'b0;
    wait_idle();

    req_tag = "R2";
    for (int i = 0; i < 300; i++) begin
      logic [15:0] d, n;
      d = 16'($urandom_range(1, 32767));
      n = 16'($urandom_range(0, int'(d)));
      if (i % 10 == 3) n = d;
      if (i % 13 == 5) n = 16'($urandom());
      if (i % 17 == 2) d = 16'($urandom());
      op(n, d);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule